// File: doc/BRIEF.md
# Compressor-Tree Dadda Multiplier (4 x 4, unsigned)

This block multiplies two 4-bit unsigned operands into an 8-bit product. The partial products come from an array of sixteen AND terms. Each term is grouped by its weight, the sum of its two bit indices. A column-compression tree then cuts the seven weight columns down to at most two bits each. It defers work in Dadda fashion: compression happens only where a column would otherwise stay too tall, and it happens as late as possible. The central column and the one after it each use a 4:2 compressor cell. That cell computes its outgoing carry only from its four primary inputs, never from its carry-in, so a carry cannot ripple sideways through a chain of compressors. One half adder and one full adder handle the remaining columns. A carry-skip adder with 4-bit skip groups adds the two rows that are left.

The operands arrive on a valid/ready stream and the product leaves on one. With `REG_OUT = 1` (the default), an output register stage holds the product. A beat is accepted when `in_valid` and `in_ready` are both high. Its product appears on the next cycle with `out_valid` set. While `out_valid` is high and `out_ready` is low, the register holds its product, and `in_ready` drops so that no new beat can overwrite it. `in_ready` is high whenever the register is empty or is being drained in the same cycle. With `REG_OUT = 0`, the path is purely combinational and the handshake passes straight through. A synchronous active-high reset clears the register.

Top module: `dadda_mul4`

## Requirements
- R1: For every one of the 256 operand pairs, the accepted product equals `in_a * in_b` as an unsigned 8-bit value.
- R2: The 4:2 compressor cell satisfies x1+x2+x3+x4+cin = sum + 2*(carry+cout) for all 32 input combinations.
- R3: The compressor's `cout` output is the same for cin=0 and cin=1 under every setting of its four primary inputs.
- R4: The reduction tree leaves two 8-bit rows whose sum equals the product, and the carry-skip adder never carries out of bit 7.
- R5: With `REG_OUT = 1`, a beat accepted at a rising edge shows `out_valid = 1` and its product on `out_prod` after that edge. A cycle with `in_ready = 1` and `in_valid = 0` leaves `out_valid = 0` after the edge.
- R6: With `REG_OUT = 1`, while `out_valid = 1` and `out_ready = 0`, the next cycle keeps `out_valid = 1` and an unchanged `out_prod`, whatever input is offered.
- R7: With `REG_OUT = 1`, `in_ready` is 1 exactly when `out_valid = 0` or `out_ready = 1`. A beat offered while `in_ready = 0` is taken once `in_ready` rises.
- R8: A synchronous reset (`rst = 1` at a rising edge) sets `out_valid = 0` and `out_prod = 0` after that edge.
- R9: With `REG_OUT = 0`, `out_prod` equals `in_a * in_b` in the same cycle, `out_valid` follows `in_valid`, and `in_ready` follows `out_ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An operand pair is offered |
| in_ready | output | 1 | The block can accept the offered pair |
| in_a | input | 4 | Unsigned multiplicand |
| in_b | input | 4 | Unsigned multiplier |
| out_valid | output | 1 | `out_prod` carries a product |
| out_ready | input | 1 | The consumer takes the product this cycle |
| out_prod | output | 8 | Unsigned product |

## Verification
The assertions assume that every input is driven to a known 0 or 1 after reset. They also assume that the reset is held for at least one rising edge before the first transfer. They further assume that `in_a` and `in_b` are held stable while a beat waits on `in_ready`. The sweep checks the tree and the adder only against operand pairs it offers itself. The bench sets every input on the falling edge and never leaves an input undriven. It keeps reset high for several cycles at the start. During stalls it keeps the offered operands constant until the beat is taken. It drives the stand-alone compressor with fully defined 5-bit patterns only.

// File: rtl/dadda_pkg.sv
package dadda_pkg;
  localparam int OP_W   = 4;            // operand width handled by the tree
  localparam int PROD_W = 2 * OP_W;     // product width
  localparam int SKIP_W = 4;            // carry-skip group width
  localparam int NCOL   = 2 * OP_W - 1; // weight columns in the partial-product array

  typedef logic [OP_W-1:0]              opnd_t;
  typedef logic [PROD_W-1:0]            prod_t;
  typedef logic [OP_W-1:0][OP_W-1:0]    ppm_t;  // ppm[i][j] = a[i] & b[j], weight i+j
endpackage

// File: rtl/dadda_cells.sv
// Half adder: two same-weight bits to a sum and a next-weight carry.
module dadda_ha (
  input  logic x,
  input  logic y,
  output logic s,
  output logic c
);
  assign s = x ^ y;
  assign c = x & y;
endmodule

// Full adder: three same-weight bits to a sum and a next-weight carry.
module dadda_fa (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic s,
  output logic c
);
  logic xy;
  assign xy = x ^ y;
  assign s  = xy ^ z;
  assign c  = xy ? z : x;
endmodule

// 4:2 compressor. cout is formed from x1..x4 alone, so a row of these
// cells never ripples. Longest path: three XOR levels (x1^x2, ^(x3^x4), ^cin).
module dadda_cmp42 (
  input  logic x1,
  input  logic x2,
  input  logic x3,
  input  logic x4,
  input  logic cin,
  output logic sum,
  output logic carry,
  output logic cout
);
  logic p12, p34, p4;
  assign p12   = x1 ^ x2;
  assign p34   = x3 ^ x4;
  assign p4    = p12 ^ p34;
  assign cout  = p12 ? x3 : x1;
  assign sum   = p4 ^ cin;
  assign carry = p4 ? cin : x4;
endmodule

// File: rtl/dadda_ppgen.sv
// Partial-product array: one AND term per operand-bit pair.
module dadda_ppgen
  import dadda_pkg::*;
(
  input  opnd_t a,
  input  opnd_t b,
  output ppm_t  ppm
);
  for (genvar i = 0; i < OP_W; i++) begin : g_row
    for (genvar j = 0; j < OP_W; j++) begin : g_col
      assign ppm[i][j] = a[i] & b[j];
    end
  end
endmodule

// File: rtl/dadda_tree.sv
// Column heights by weight 0..6: 1 2 3 4 3 2 1.
// One stage brings every column to two bits or fewer:
//   w2 : half adder on two bits, one bit passes, carry feeds the w3 cell
//   w3 : 4:2 compressor (central column), cin from the w2 half adder
//   w4 : 4:2 compressor, cin from the w3 cell cout
//   w5 : full adder on three bits, the w4 cout passes
//   w6 : one bit passes plus the w5 carry
module dadda_tree
  import dadda_pkg::*;
(
  input  ppm_t  ppm,
  output prod_t row_a,
  output prod_t row_b
);
  logic s2, c2;
  logic s3, k3, o3;
  logic s4, k4, o4;
  logic s5, c5;

  dadda_ha u_w2 (.x(ppm[0][2]), .y(ppm[1][1]), .s(s2), .c(c2));

  dadda_cmp42 u_w3 (
    .x1(ppm[0][3]), .x2(ppm[1][2]), .x3(ppm[2][1]), .x4(ppm[3][0]),
    .cin(c2), .sum(s3), .carry(k3), .cout(o3)
  );

  dadda_cmp42 u_w4 (
    .x1(ppm[1][3]), .x2(ppm[2][2]), .x3(ppm[3][1]), .x4(k3),
    .cin(o3), .sum(s4), .carry(k4), .cout(o4)
  );

  dadda_fa u_w5 (.x(ppm[2][3]), .y(ppm[3][2]), .z(k4), .s(s5), .c(c5));

  assign row_a = {1'b0, ppm[3][3], s5, s4, s3, s2, ppm[0][1], ppm[0][0]};
  assign row_b = {1'b0, c5, o4, 1'b0, 1'b0, ppm[2][0], ppm[1][0], 1'b0};
endmodule

// File: rtl/dadda_skip_add.sv
// Carry-skip adder: ripple inside each GRP-bit group; a group whose bits
// all propagate passes its incoming carry straight to the next group.
// W must be a multiple of GRP.
module dadda_skip_add #(
  parameter int W   = 8,
  parameter int GRP = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         cout
);
  localparam int NGRP = W / GRP;

  logic [NGRP:0] gc;
  assign gc[0] = cin;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [GRP:0]   rc;
    logic [GRP-1:0] pv;
    logic           gp;
    assign rc[0] = gc[g];
    for (genvar k = 0; k < GRP; k++) begin : g_bit
      localparam int B = g * GRP + k;
      assign pv[k]    = x[B] ^ y[B];
      assign s[B]     = pv[k] ^ rc[k];
      assign rc[k+1]  = (x[B] & y[B]) | (pv[k] & rc[k]);
    end
    assign gp      = &pv;
    assign gc[g+1] = gp ? gc[g] : rc[GRP];
  end

  assign cout = gc[NGRP];
endmodule

// File: rtl/dadda_mul4.sv
module dadda_mul4
  import dadda_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_a,
  input  logic [OP_W-1:0]   in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PROD_W-1:0] out_prod
);
  ppm_t  ppm;
  prod_t row_a, row_b, prod_c;
  logic  sum_cout;

  dadda_ppgen u_pp (.a(in_a), .b(in_b), .ppm(ppm));
  dadda_tree  u_tree (.ppm(ppm), .row_a(row_a), .row_b(row_b));
  dadda_skip_add #(.W(PROD_W), .GRP(SKIP_W)) u_add (
    .x(row_a), .y(row_b), .cin(1'b0), .s(prod_c), .cout(sum_cout)
  );

  if (REG_OUT) begin : g_reg
    logic  vld_q;
    prod_t prod_q;
    assign in_ready = !vld_q || out_ready;
    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q  <= 1'b0;
        prod_q <= '0;
      end else if (in_ready) begin
        vld_q <= in_valid;
        if (in_valid) prod_q <= prod_c;
      end
    end
    assign out_valid = vld_q;
    assign out_prod  = prod_q;
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_prod  = prod_c;
  end
endmodule

// File: rtl/dadda_mul4_chk.sv
module dadda_mul4_chk
  import dadda_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [OP_W-1:0]   in_a,
  input logic [OP_W-1:0]   in_b,
  input logic              out_valid,
  input logic              out_ready,
  input logic [PROD_W-1:0] out_prod,
  input logic [PROD_W-1:0] row_a,
  input logic [PROD_W-1:0] row_b,
  input logic              sum_cout
);
  logic [PROD_W-1:0] a_ext, b_ext, ab;
  logic [PROD_W:0]   rows_total;
  assign a_ext      = PROD_W'(in_a);
  assign b_ext      = PROD_W'(in_b);
  assign ab         = a_ext * b_ext;
  assign rows_total = (PROD_W+1)'(row_a) + (PROD_W+1)'(row_b);

  AST_ROWS_EXACT: assert property (@(posedge clk) disable iff (rst)
    rows_total == (PROD_W+1)'(ab)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    !sum_cout); // R4

  if (REG_OUT) begin : g_reg
    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> (out_valid && out_prod == $past(ab))); // R5
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_prod))); // R6
    AST_READY_BLOCK: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |-> !in_ready); // R7
    AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (!out_valid && out_prod == '0)); // R8
  end else begin : g_comb
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
      out_valid == in_valid && in_ready == out_ready && out_prod == ab); // R9
  end
endmodule

bind dadda_mul4 dadda_mul4_chk #(.REG_OUT(REG_OUT)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
  .out_prod(out_prod), .row_a(row_a), .row_b(row_b), .sum_cout(sum_cout)
);

// File: tb/dadda_mul4_tb_top.sv
module dadda_mul4_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       out_ready = 1'b1;
  logic [3:0] in_a = '0, in_b = '0;
  logic       in_ready, out_valid;
  logic [7:0] out_prod;

  logic       c_ready = 1'b1;
  logic       c_in_ready, c_out_valid;
  logic [7:0] c_prod;

  logic x1 = 0, x2 = 0, x3 = 0, x4 = 0, xc = 0;
  logic cs, ck, co;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk; // 50 MHz

  dadda_mul4 #(.REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_prod(out_prod)
  );

  dadda_mul4 #(.REG_OUT(1'b0)) comb_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(c_in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(c_out_valid), .out_ready(c_ready),
    .out_prod(c_prod)
  );

  dadda_cmp42 cmp_i (.x1(x1), .x2(x2), .x3(x3), .x4(x4), .cin(xc),
                     .sum(cs), .carry(ck), .cout(co));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int co0;
    // Compressor unit test: R2 arithmetic identity, R3 cout ignores cin
    for (int v = 0; v < 32; v++) begin
      {x1, x2, x3, x4, xc} = 5'(v);
      #1;
      check("R2 compressor identity", int'(cs) + 2 * (int'(ck) + int'(co)),
            int'(x1) + int'(x2) + int'(x3) + int'(x4) + int'(xc));
    end
    for (int v = 0; v < 16; v++) begin
      {x1, x2, x3, x4} = 4'(v);
      xc = 1'b0; #1; co0 = int'(co);
      xc = 1'b1; #1;
      check("R3 cout independent of cin", int'(co), co0);
    end

    // Reset state: R8
    repeat (3) @(negedge clk);
    check("R8 reset out_valid", int'(out_valid), 0);
    check("R8 reset out_prod", int'(out_prod), 0);
    rst = 1'b0;

    // Exhaustive sweep, back to back: R1, R5, R9 (R4 by assertion)
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      in_a = 4'(i >> 4); in_b = 4'(i); in_valid = 1'b1;
      c_ready = 1'(i & 1);
      #1;
      check("R9 comb product", int'(c_prod), (i >> 4) * (i & 15));
      check("R9 comb valid/ready", int'({c_out_valid, c_in_ready}), 2 | (i & 1));
      @(negedge clk);
      check("R1/R5 registered product", int'(out_prod), (i >> 4) * (i & 15));
      check("R5 out_valid after accept", int'(out_valid), 1);
    end

    // Idle cycle with in_ready high: R5
    in_valid = 1'b0;
    @(negedge clk);
    check("R5 bubble clears out_valid", int'(out_valid), 0);

    // Back-pressure: R6, R7
    in_a = 4'd9; in_b = 4'd7; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    check("R5 product 9*7", int'(out_prod), 63);
    out_ready = 1'b0; in_a = 4'd3; in_b = 4'd5;
    #1;
    check("R7 in_ready low when stalled", int'(in_ready), 0);
    @(negedge clk);
    check("R6 stalled product held", int'(out_prod), 63);
    check("R6 stalled valid held", int'(out_valid), 1);
    out_ready = 1'b1;
    #1;
    check("R7 in_ready high when draining", int'(in_ready), 1);
    @(negedge clk);
    check("R7 waiting beat taken", int'(out_prod), 15);

    // Maximum operands then mid-stream reset: R1, R8
    in_a = 4'd15; in_b = 4'd15;
    @(negedge clk);
    check("R1 product 15*15", int'(out_prod), 225);
    rst = 1'b1;
    @(negedge clk);
    check("R8 reset clears out_valid", int'(out_valid), 0);
    check("R8 reset clears out_prod", int'(out_prod), 0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);

    summary();
    $finish;
  end
endmodule